// File: doc/BRIEF.md
# I2S Audio Serial Formatter

This block moves fixed-length audio words across a two-channel serial audio link in both directions. On each bit period, marked by a one-cycle `bit_tick` strobe, it shifts one transmit bit out on `sd_out` and captures one receive bit from `sd_in`. The channel (word-select) signal is driven on `ws_out`, the line that would otherwise serve as a slave select. Words are sent and received MSB first. Each channel slot lasts `W` bit periods, so a frame lasts `2*W` bit periods.

Transmit words come from a FIFO-style source. `tx_valid` and `tx_data` show the head entry, and `tx_pop` consumes it in the cycle it is asserted. Received words go to a sink as a one-cycle `rx_push` pulse, with `rx_data` and a channel flag `rx_right`. Four static mode inputs shape the traffic:

- `mute` zeroes the transmit line but keeps consuming words.
- `pause` zeroes the line and stops all source and sink traffic.
- `mono` sends one word on both channels and keeps only left receive words.
- `left_just` moves the data so that it starts in the same bit period as the channel change, instead of one period later.

Mode inputs are meant to be changed only while the block is held in reset.

Top module: `i2s_fmt`

## Requirements
- R1: After reset, before the first tick: `ws_out` is 0, `sd_out` is 0, and `rx_push`, `tx_pop` and `tx_underrun` are 0.
- R2: `ws_out` starts at 0, which selects the left channel, and toggles after every `W` ticks. It changes only on a clock edge where `bit_tick` is high.
- R3: With `left_just`=0, the word of a slot appears MSB first on `sd_out`, starting one tick after the `ws_out` change. The first bit period of each slot carries the LSB of the previous slot's word.
- R4: With `left_just`=1, the MSB of a slot's word is on `sd_out` in the same bit period in which `ws_out` changes.
- R5: In stereo mode (`mono`=0), one source word is popped at each slot boundary, in the same cycle as the tick. That word is sent in the slot that starts there. The first slot after reset sends zeros.
- R6: In mono mode, one word is popped per frame, at the boundary that starts a left slot. The same word is sent in that left slot and in the right slot that follows it. The first right slot after reset sends zeros.
- R7: With `mute`=1, `sd_out` stays 0 while words are popped exactly as without mute.
- R8: With `pause`=1, `sd_out` stays 0, no word is popped, no word is pushed, and no underrun is flagged.
- R9: When a word is needed and `tx_valid` is 0, the slot sends zeros (in mono mode, both slots of that frame do). `tx_underrun` then pulses for one cycle, in the cycle after the tick.
- R10: Each received slot is pushed as one word, MSB first, with `rx_right`=1 for right-channel words. The alignment follows the same `left_just` setting as the transmit side. `rx_push` is a one-cycle pulse in the cycle after the tick that completes the word.
- R11: In mono mode, only left-channel receive words are pushed. Right-channel words are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per serial bit period |
| mute | input | 1 | Send zeros, keep popping words |
| pause | input | 1 | Send zeros, stop all word traffic |
| mono | input | 1 | One word per frame on both channels; drop right receive |
| left_just | input | 1 | 1: data starts with the channel change; 0: one-bit lag |
| tx_valid | input | 1 | Source holds a word |
| tx_data | input | W | Source head word |
| tx_pop | output | 1 | Consume source head word this cycle |
| tx_underrun | output | 1 | Pulse: word needed while source empty |
| sd_out | output | 1 | Serial transmit data |
| ws_out | output | 1 | Channel select, 0 = left |
| sd_in | input | 1 | Serial receive data |
| rx_data | output | W | Received word |
| rx_right | output | 1 | Received word belongs to the right channel |
| rx_push | output | 1 | Pulse: `rx_data` valid |

## Verification
`ws_out` and `sd_out` are registered and change on the clock edge where `bit_tick` is high. The bench therefore samples them on the falling edge that follows each tick, and computes the expected value from the count of ticks seen so far. `tx_pop` is combinational in the tick cycle, so the bench's source model advances on the same rising edge. `tx_underrun` and `rx_push` are registered and appear for the one cycle after the tick. The bench counts them on falling edges, so each pulse is seen exactly once. The pop, underrun and push totals, and every captured word with its channel, are compared after the last tick of each scenario.

// File: rtl/i2s_fmt_pkg.sv
package i2s_fmt_pkg;
  // Static mode controls, held constant while the link runs
  typedef struct packed {
    logic mute;
    logic pause;
    logic mono;
    logic left_just;
  } i2s_mode_t;
endpackage

// File: rtl/i2s_slot_ctr.sv
module i2s_slot_ctr #(
  parameter int W = 16,
  localparam int CW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  output logic [CW-1:0] pos,
  output logic          ws,
  output logic          slot_start,
  output logic          slot_end
);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] pos_d;
  logic          ws_d;

  assign slot_start = (pos == '0);
  assign slot_end   = (pos == LAST);

  always_comb begin
    pos_d = pos;
    ws_d  = ws;
    if (bit_tick) begin
      if (slot_end) begin
        pos_d = '0;
        ws_d  = ~ws;
      end else begin
        pos_d = pos + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
      ws  <= 1'b0;
    end else if (bit_tick) begin
      pos <= pos_d;
      ws  <= ws_d;
    end
  end
endmodule

// File: rtl/i2s_tx_path.sv
module i2s_tx_path
  import i2s_fmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_tick,
  input  logic         slot_end,
  input  logic         ws,
  input  i2s_mode_t    md,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  output logic         tx_pop,
  output logic         tx_underrun,
  output logic         sd_out
);
  logic [W-1:0] shift_q, shift_d;
  logic [W-1:0] held_q, held_d;
  logic [W-1:0] load_word;
  logic         lag_q, lag_d;
  logic         und_d;
  logic         need_pop, take;

  // A word is needed at every boundary in stereo, only before a left slot in mono
  assign need_pop = !md.pause && (!md.mono || ws);
  assign take     = bit_tick && slot_end && need_pop;
  assign tx_pop   = take && tx_valid;
  assign sd_out   = md.left_just ? shift_q[W-1] : lag_q;

  always_comb begin
    if (md.pause) begin
      load_word = '0;
    end else if (need_pop) begin
      load_word = (tx_valid && !md.mute) ? tx_data : '0;
    end else begin
      load_word = md.mute ? '0 : held_q;
    end
  end

  always_comb begin
    held_d  = held_q;
    shift_d = shift_q;
    lag_d   = lag_q;
    und_d   = take && !tx_valid;
    if (take) begin
      held_d = tx_valid ? tx_data : '0;
    end
    if (bit_tick) begin
      lag_d   = shift_q[W-1];
      shift_d = slot_end ? load_word : {shift_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q     <= '0;
      held_q      <= '0;
      lag_q       <= 1'b0;
      tx_underrun <= 1'b0;
    end else begin
      tx_underrun <= und_d;
      if (bit_tick) begin
        shift_q <= shift_d;
        held_q  <= held_d;
        lag_q   <= lag_d;
      end
    end
  end
endmodule

// File: rtl/i2s_rx_path.sv
module i2s_rx_path
  import i2s_fmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_tick,
  input  logic         slot_start,
  input  logic         slot_end,
  input  logic         ws,
  input  i2s_mode_t    md,
  input  logic         sd_in,
  output logic [W-1:0] rx_data,
  output logic         rx_right,
  output logic         rx_push
);
  logic [W-1:0] sh_q, sh_d;
  logic [W-1:0] word_nx;
  logic         armed_q, armed_d;
  logic         done, chan, push_d;

  assign word_nx = {sh_q[W-2:0], sd_in};

  // Left-justified words end with the slot; lagged words end one bit into the next slot
  always_comb begin
    if (md.left_just) begin
      done = slot_end;
      chan = ws;
    end else begin
      done = slot_start && armed_q;
      chan = ~ws;
    end
    push_d  = bit_tick && done && !md.pause && !(md.mono && chan);
    sh_d    = bit_tick ? word_nx : sh_q;
    armed_d = armed_q || (bit_tick && slot_end);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      armed_q  <= 1'b0;
      rx_push  <= 1'b0;
      rx_data  <= '0;
      rx_right <= 1'b0;
    end else begin
      rx_push <= push_d;
      if (bit_tick) begin
        sh_q    <= sh_d;
        armed_q <= armed_d;
      end
      if (push_d) begin
        rx_data  <= word_nx;
        rx_right <= chan;
      end
    end
  end
endmodule

// File: rtl/i2s_fmt.sv
module i2s_fmt
  import i2s_fmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_tick,
  input  logic         mute,
  input  logic         pause,
  input  logic         mono,
  input  logic         left_just,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  output logic         tx_pop,
  output logic         tx_underrun,
  output logic         sd_out,
  output logic         ws_out,
  input  logic         sd_in,
  output logic [W-1:0] rx_data,
  output logic         rx_right,
  output logic         rx_push
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  i2s_mode_t     md;
  logic [CW-1:0] pos;
  logic          ws, slot_start, slot_end;

  assign md     = '{mute: mute, pause: pause, mono: mono, left_just: left_just};
  assign ws_out = ws;

  i2s_slot_ctr #(.W(W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .pos(pos), .ws(ws), .slot_start(slot_start), .slot_end(slot_end)
  );

  i2s_tx_path #(.W(W)) u_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .slot_end(slot_end),
    .ws(ws), .md(md), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_pop(tx_pop), .tx_underrun(tx_underrun), .sd_out(sd_out)
  );

  i2s_rx_path #(.W(W)) u_rx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .slot_start(slot_start),
    .slot_end(slot_end), .ws(ws), .md(md), .sd_in(sd_in),
    .rx_data(rx_data), .rx_right(rx_right), .rx_push(rx_push)
  );
endmodule

// File: rtl/i2s_fmt_chk.sv
module i2s_fmt_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic pause,
  input logic mono,
  input logic tx_valid,
  input logic tx_pop,
  input logic tx_underrun,
  input logic ws_out,
  input logic rx_push,
  input logic rx_right
);
  // R2: channel select only moves on a tick edge
  a_r2_ws_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_tick) |-> $stable(ws_out));

  // R5: a pop happens only in a tick cycle with data present
  a_r5_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> (bit_tick && tx_valid));

  // R8: no source traffic while paused
  a_r8_pause_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    pause |-> !tx_pop);

  // R8: no sink traffic while paused
  a_r8_pause_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pause) |-> !rx_push);

  // R9: underrun is a single-cycle pulse
  a_r9_underrun_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |=> !tx_underrun);

  // R11: mono never delivers a right-channel word
  a_r11_mono_left_only: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && $past(mono)) |-> !rx_right);
endmodule

bind i2s_fmt i2s_fmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .pause(pause), .mono(mono),
  .tx_valid(tx_valid), .tx_pop(tx_pop), .tx_underrun(tx_underrun),
  .ws_out(ws_out), .rx_push(rx_push), .rx_right(rx_right)
);

// File: tb/test_i2s_fmt.sv
module test_i2s_fmt;
  localparam int W = 16;
  localparam int TDIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic mute = 1'b0, pause = 1'b0, mono = 1'b0, left_just = 1'b0;
  logic sd_in = 1'b0;
  logic tx_valid, tx_pop, tx_underrun, sd_out, ws_out, rx_right, rx_push;
  logic [W-1:0] tx_data, rx_data;

  logic [W-1:0] txq [0:63];
  logic [W-1:0] rxq [0:63];
  logic [W-1:0] got_w [0:63];
  logic         got_r [0:63];
  int nwords = 0;
  int pop_cnt, und_cnt, n_got;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  i2s_fmt #(.W(W)) i_i2s_fmt (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .mute(mute), .pause(pause),
    .mono(mono), .left_just(left_just), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_pop(tx_pop), .tx_underrun(tx_underrun), .sd_out(sd_out), .ws_out(ws_out),
    .sd_in(sd_in), .rx_data(rx_data), .rx_right(rx_right), .rx_push(rx_push)
  );

  // Source FIFO model
  assign tx_valid = (pop_cnt < nwords);
  assign tx_data  = txq[pop_cnt[5:0]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) pop_cnt <= 0;
    else if (tx_pop) pop_cnt <= pop_cnt + 1;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      n_got = 0;
      und_cnt = 0;
    end else begin
      if (tx_underrun) und_cnt = und_cnt + 1;
      if (rx_push && n_got < 64) begin
        got_w[n_got] = rx_data;
        got_r[n_got] = rx_right;
        n_got = n_got + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Word sent in slot s (slot 0 starts at reset)
  function automatic logic [W-1:0] tx_word(input int s);
    int idx;
    if (pause || s == 0) return '0;
    if (mono) begin
      if (s == 1) return '0;
      idx = s / 2 - 1;
    end else begin
      idx = s - 1;
    end
    if (idx >= nwords || mute) return '0;
    return txq[idx];
  endfunction

  function automatic logic tx_lj(input int t);
    logic [W-1:0] w;
    w = tx_word(t / W);
    return w[W-1-(t % W)];
  endfunction

  function automatic logic rx_lj(input int u);
    logic [W-1:0] w;
    w = rxq[(u / W) % 64];
    return w[W-1-(u % W)];
  endfunction

  task automatic run(input bit m_mute, input bit m_pause, input bit m_mono,
                     input bit m_lj, input int nw, input int nslots);
    int nticks, need, exp_pop, exp_und, exp_push;
    logic exp_sd, exp_ws;
    string tag;
    @(negedge clk);
    rst_n = 1'b0;
    bit_tick = 1'b0;
    sd_in = 1'b0;
    mute = m_mute; pause = m_pause; mono = m_mono; left_just = m_lj;
    nwords = nw;
    for (int i = 0; i < 64; i++) begin
      txq[i] = W'($urandom);
      rxq[i] = W'($urandom);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: state before the first tick
    chk(ws_out == 1'b0, "R1 ws", ws_out, 0);
    chk(sd_out == 1'b0, "R1 sd", sd_out, 0);
    chk(!rx_push && !tx_underrun && !tx_pop, "R1 strobes",
        {rx_push, tx_underrun, tx_pop}, 0);
    tag = m_pause ? "R8" : m_mute ? "R7" : m_mono ? "R6" : m_lj ? "R4" : "R3";
    nticks = nslots * W + 1;
    for (int t = 0; t < nticks; t++) begin
      exp_ws = 1'(((t / W) % 2));
      exp_sd = m_lj ? tx_lj(t) : ((t == 0) ? 1'b0 : tx_lj(t - 1));
      chk(ws_out == exp_ws, "R2 ws", ws_out, exp_ws);
      chk(sd_out == exp_sd, tag, sd_out, exp_sd);
      sd_in = m_lj ? rx_lj(t) : ((t == 0) ? 1'b0 : rx_lj(t - 1));
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
      repeat (TDIV - 1) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    need     = m_pause ? 0 : (m_mono ? nslots / 2 : nslots);
    exp_pop  = (need < nw) ? need : nw;
    exp_und  = need - exp_pop;
    exp_push = m_pause ? 0 : (m_mono ? (nslots + 1) / 2 : nslots);
    chk(pop_cnt == exp_pop, m_mono ? "R6 pops" : (m_mute ? "R7 pops" : "R5 pops"),
        pop_cnt, exp_pop);
    chk(und_cnt == exp_und, m_pause ? "R8 underrun" : "R9 underrun", und_cnt, exp_und);
    chk(n_got == exp_push, m_pause ? "R8 pushes" : "R10 pushes", n_got, exp_push);
    if (n_got == exp_push) begin
      for (int i = 0; i < n_got; i++) begin
        int m;
        m = m_mono ? 2 * i : i;
        chk(got_w[i] == rxq[m], "R10 word", got_w[i], rxq[m]);
        chk(got_r[i] == 1'(m % 2), m_mono ? "R11 chan" : "R10 chan", got_r[i], m % 2);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    run(0, 0, 0, 0, 20, 6);  // R3 R5 R10 stereo lagged
    run(0, 0, 0, 1, 20, 6);  // R4 stereo left-justified
    run(0, 0, 1, 0, 20, 7);  // R6 R11 mono lagged
    run(0, 0, 1, 1, 20, 6);  // R6 R11 mono left-justified
    run(1, 0, 0, 0, 20, 5);  // R7 mute
    run(0, 1, 0, 1, 20, 5);  // R8 pause
    run(0, 0, 0, 0, 2, 6);   // R9 stereo underrun
    run(0, 0, 1, 1, 1, 6);   // R9 mono underrun
    for (int k = 0; k < 4; k++) begin
      run(1'($urandom), 1'($urandom % 4 == 0), 1'($urandom), 1'($urandom),
          int'($urandom % 9), 4 + int'($urandom % 4));
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule